// File: doc/BRIEF.md
# Even-Ratio Clock Divider

This block derives a slower clock from a single input clock. A 3-bit select code chooses one of eight even division ratios, from 2 up to 16. The high and low halves of the divided clock are always the same number of input cycles, so the duty cycle is exactly 50% for every ratio. The divided clock comes straight from a flip-flop, so it has no combinational glitches.

A new select value never cuts a phase short. The block keeps running at its current ratio until the divided clock falls, which ends a full period. It loads the new code at that edge, and both halves of the next period use it. The synchronous clear has the same guarantee. If the clear arrives while the output is low, the output and the half-period counter are held at rest immediately. If it arrives while the output is high, the high phase first runs to its full length, and only then is the output pulled low and held there.

Top module: `even_clk_div`

## Requirements
- R1: Select code k (0 to 7) gives a divided-clock period of 2×(k+1) input cycles, measured from one falling edge of `clk_o` to the next.
- R2: Every high phase and every low phase of `clk_o` lasts exactly k+1 input cycles, where k is the active code.
- R3: A change on `ratio_sel_i` takes effect only at the input edge where `clk_o` falls. That edge loads the code sampled on it, and the following low and high phases both use the new code.
- R4: While `sync_clr_i` is high and `clk_o` is low, `clk_o` stays low, the counter is cleared and the code is reloaded on every edge. After release, the low phase lasts k+1 more edges, where k is the code sampled on the last cleared edge.
- R5: If `sync_clr_i` is high while `clk_o` is high, the high phase completes its full k+1 cycles before `clk_o` falls. After that, R4 applies.
- R6: While `rst_ni` is low, `clk_o` is low. After release, the active code is 0 until the first falling edge of `clk_o`.
- R7: Apart from asynchronous reset, no phase of `clk_o` is ever shorter than k+1 cycles of the code active during that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_clr_i | input | 1 | Synchronous clear; restarts the divider without runt phases |
| ratio_sel_i | input | 3 | Division code k; ratio is 2×(k+1) |
| clk_o | output | 1 | Divided clock, 50% duty cycle |

## Verification
Any wrong value in the half-period counter or the active-code register changes the length of the `clk_o` phase in progress, so the error shows at the next edge of `clk_o`, at most k+1 input cycles later. If the counter passes its limit, the output stays stuck, and the error appears as a phase running longer than k+1 cycles. If the code is loaded at the wrong moment, a phase takes the length of the wrong code. To catch this, every phase length is compared against the code that should have been active, including the phases around a clear, around a code change and after reset.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Per-cycle control events decoded from the divider state
  typedef struct packed {
    logic clr_low;  // clear request seen while the output rests low
    logic wrap;     // half-period counter reached its limit
    logic fall;     // output is about to go high-to-low
  } div_evt_t;

endpackage

// File: rtl/div_ratio_reg.sv
module div_ratio_reg #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] ratio_o
);

  logic [SEL_W-1:0] ratio_d;
  logic [SEL_W-1:0] ratio_q;

  always_comb begin
    ratio_d = ratio_q;
    if (load_en_i) begin
      ratio_d = sel_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= '0;
    end else begin
      ratio_q <= ratio_d;
    end
  end

  assign ratio_o = ratio_q;

endmodule

// File: rtl/div_phase_cnt.sv
module div_phase_cnt #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_en_i,
  input  logic [SEL_W-1:0] limit_i,
  output logic [SEL_W-1:0] cnt_o,
  output logic             wrap_o
);

  localparam logic [SEL_W-1:0] CntOne = SEL_W'(1);

  logic [SEL_W-1:0] cnt_d;
  logic [SEL_W-1:0] cnt_q;
  logic             at_limit;

  assign at_limit = (cnt_q == limit_i);

  always_comb begin
    cnt_d = cnt_q + CntOne;
    if (clr_en_i || at_limit) begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = at_limit;

endmodule

// File: rtl/div_out_flop.sv
module div_out_flop
  import clkdiv_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  div_evt_t evt_i,
  output logic     q_o
);

  logic q_d;
  logic q_q;

  always_comb begin
    q_d = q_q;
    if (evt_i.clr_low) begin
      q_d = 1'b0;
    end else if (evt_i.wrap) begin
      q_d = ~q_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= 1'b0;
    end else begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;

endmodule

// File: rtl/even_clk_div.sv
module even_clk_div
  import clkdiv_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_clr_i,
  input  logic [SEL_W-1:0] ratio_sel_i,
  output logic             clk_o
);

  logic [SEL_W-1:0] ratio_q;
  logic [SEL_W-1:0] cnt_q;
  logic             wrap;
  logic             out_q;
  div_evt_t         evt;

  // Event decode: clear acts at once only while resting low; a high
  // phase always runs to its limit first.
  always_comb begin
    evt.clr_low = sync_clr_i & ~out_q;
    evt.wrap    = wrap;
    evt.fall    = wrap & out_q;
  end

  div_ratio_reg #(.SEL_W(SEL_W)) u_ratio (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_en_i(evt.fall | evt.clr_low),
    .sel_i    (ratio_sel_i),
    .ratio_o  (ratio_q)
  );

  div_phase_cnt #(.SEL_W(SEL_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_en_i(evt.clr_low),
    .limit_i (ratio_q),
    .cnt_o   (cnt_q),
    .wrap_o  (wrap)
  );

  div_out_flop u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt),
    .q_o   (out_q)
  );

  assign clk_o = out_q;

endmodule

// File: rtl/even_clk_div_chk.sv
module even_clk_div_chk #(
  parameter int SEL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             clk_o,
  input logic [SEL_W-1:0] cnt,
  input logic [SEL_W-1:0] k_act
);

  // R1
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= k_act);

  // R2
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != k_act) |=> $stable(clk_o));

  // R3
  ratio_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(clk_o && cnt == k_act) && !(clr_i && !clk_o)) |=> $stable(k_act));

  // R4
  clr_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !clk_o) |=> (!clk_o && cnt == '0));

  // R5
  clr_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && clk_o && cnt != k_act) |=> clk_o);

endmodule

bind even_clk_div even_clk_div_chk #(.SEL_W(SEL_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .clr_i (sync_clr_i),
  .clk_o (clk_o),
  .cnt   (cnt_q),
  .k_act (ratio_q)
);

// File: tb/even_clk_div_tb.sv
`timescale 1ns/1ps
module even_clk_div_tb;

  logic       clk;
  logic       rst_n;
  logic       clr;
  logic [2:0] sel;
  logic       clk_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  even_clk_div #(.SEL_W(3)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .sync_clr_i (clr),
    .ratio_sel_i(sel),
    .clk_o      (clk_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int half_len(int k);
    return k + 1;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp, string what);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Phase-length monitor: samples 1 ns after each rising input edge
  logic  last_o;
  int    run;
  int    cur_k;
  int    low_len;
  bit    period_ok;
  bit    stuck_rep;
  string tag;

  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      check(clk_o == 1'b0, "R6", int'(clk_o), 0, "clk_o during reset");
      last_o = 1'b0; run = 1; cur_k = 0; tag = "R6";
      period_ok = 0; stuck_rep = 0;
    end else begin
      if (clk_o !== last_o) begin
        check(run == half_len(cur_k), tag, run, half_len(cur_k), "phase length");
        if (clk_o == 1'b0) begin
          if (period_ok)
            check(low_len + run == 2 * half_len(cur_k), "R1", low_len + run,
                  2 * half_len(cur_k), "period");
          tag = (int'(sel) != cur_k) ? "R3" : "R2";
          cur_k = int'(sel);
          period_ok = 1;
        end else begin
          low_len = run;
        end
        run = 1;
        stuck_rep = 0;
      end else begin
        run++;
      end
      if (clr && clk_o == 1'b1) tag = "R5";
      if (clr && clk_o == 1'b0) begin
        run = 1; cur_k = int'(sel); tag = "R4"; period_ok = 0;
      end
      if (run > half_len(cur_k) && !stuck_rep) begin
        stuck_rep = 1;
        check(1'b0, "R7", run, half_len(cur_k), "phase overran");
      end
      last_o = clk_o;
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_level(logic v);
    @(negedge clk);
    while (clk_o !== v) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R7 watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    process::self().srandom(32'd1729);
    rst_n = 1'b0; clr = 1'b0; sel = 3'd5;
    cycles(5);
    // R6: default code 0 -> first phases one cycle each, then code 5
    rst_n = 1'b1;
    cycles(40);

    // R1, R2: every ratio in turn
    for (int k = 0; k < 8; k++) begin
      sel = 3'(k);
      cycles(6 * 2 * (k + 1));
    end

    // R3: change mid-high and mid-low
    sel = 3'd6; cycles(40);
    wait_level(1'b1); cycles(2); sel = 3'd1; cycles(30);
    wait_level(1'b0); sel = 3'd7; cycles(50);
    wait_level(1'b0); cycles(3); sel = 3'd2; cycles(30);

    // R5: clear while high
    sel = 3'd7; cycles(40);
    wait_level(1'b1); cycles(1); clr = 1'b1; cycles(20); clr = 1'b0; cycles(40);

    // R4: clear while low, code changed during clear
    wait_level(1'b0); cycles(1); clr = 1'b1; cycles(2); sel = 3'd3; cycles(2);
    clr = 1'b0; cycles(40);
    // R4: single-cycle clear
    wait_level(1'b0); clr = 1'b1; cycles(1); clr = 1'b0; cycles(30);

    // Random phase
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      if ($urandom_range(59, 0) == 0) sel = 3'($urandom_range(7, 0));
      if (!clr && $urandom_range(299, 0) == 0) clr = 1'b1;
      else if (clr && $urandom_range(7, 0) == 0) clr = 1'b0;
    end
    clr = 1'b0;
    cycles(40);
    finish_run();
  end

endmodule